// File: doc/BRIEF.md
# Frame Skew Meter

The frame skew meter measures how late a frame-evaluation input makes its active edge relative to the active edge of the frame pulse. The result has a resolution of half a master-clock period. A processor controls the measurement with a single start control level. The meter reports back through a completion flag and a 12-bit offset word.

A mode input selects the frame format. Format 0 compares falling edges, and format 1 compares rising edges. Frames are delimited purely by the frame pulse, so the meter works at any frame length. The evaluation input is sampled on both clock edges, which gives the half-period resolution without a second clock.

A measurement takes the whole frame that follows the first frame-pulse edge after the start rises. Completion is flagged at the next frame-pulse edge. The result then stays readable until the next measurement completes.

Top module: `frame_skew_meter`

## Requirements
- R1: While reset is asserted and right after it is released, `done_o` is 0 and `result_o` is 0.
- R2: A rise of `start_i` arms a measurement only when `start_i` has been low across at least two consecutive active frame-pulse edges (one full frame). A rise with less low time than that is ignored, and `done_o` stays 0 until `start_i` is low again.
- R3: `done_o` rises one clock after the second active frame-pulse edge following an accepted `start_i` rise is sampled on a rising clock edge. It stays 1 while `start_i` stays high.
- R4: The result is the position of the first active evaluation edge in the frame after the first active frame-pulse edge following the start. Position 0 means the edge was observed at the same rising clock edge as the frame-pulse edge. Each later half clock period adds 1: falling-edge samples are odd positions and rising-edge samples are even positions.
- R5: With `mode_i` = 0, the active edges of both `fp_i` and `fe_i` are their high-to-low transitions.
- R6: With `mode_i` = 1, the active edges of both `fp_i` and `fe_i` are their low-to-high transitions.
- R7: If no active evaluation edge occurs in the measured frame, the result is all ones (4095).
- R8: `done_o` returns to 0 one clock after `start_i` is seen low. `result_o` keeps its value until the next measurement completes.
- R9: If `start_i` goes low before completion, the measurement is abandoned, `done_o` does not rise and `result_o` is unchanged.
- R10: Only the first active evaluation edge in the measured frame counts. Later edges in the same frame do not change the result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Master clock; both of its edges sample the evaluation input |
| rst_n | input | 1 | Asynchronous reset, active low |
| mode_i | input | 1 | Frame format: 0 falling-edge compare, 1 rising-edge compare |
| start_i | input | 1 | Measurement start control level |
| fp_i | input | 1 | Frame pulse |
| fe_i | input | 1 | Frame-evaluation input whose lag is measured |
| done_o | output | 1 | Measurement complete flag |
| result_o | output | RES_W (12) | Measured offset in half clock periods, all ones when no edge was seen |

## Verification
The assertions assume that `start_i` and `mode_i` change synchronously and that `mode_i` is held steady for the whole of a measurement. They also assume the frame pulse returns to its idle level well before the next frame. The stimulus drives every input a quarter clock period before a clock edge, so each sample point sees a settled value. It changes the mode only while the start level is low and at least two frames pass before the next start. Frame pulses and evaluation pulses are two clock periods wide, and each evaluation pulse ends inside the frame it belongs to.

// File: rtl/fskew_pkg.sv
package fskew_pkg;

    // frame-pulse edges that must pass with the start level low before a rise is accepted
    localparam int unsigned QUAL_EDGES = 2;

    typedef enum logic [1:0] {
        MS_IDLE   = 2'd0,
        MS_ARMED  = 2'd1,
        MS_WINDOW = 2'd2,
        MS_DONE   = 2'd3
    } meas_state_e;

endpackage

// File: rtl/fskew_sampler.sv
module fskew_sampler (
    input  logic clk,
    input  logic rst_n,
    input  logic fp_i,
    input  logic fe_i,
    output logic fp_now_q,
    output logic fp_old_q,
    output logic fe_half_old_q,
    output logic fe_now_q,
    output logic fe_half_new_q
);

    // rising-edge samples
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fp_now_q      <= 1'b0;
            fp_old_q      <= 1'b0;
            fe_now_q      <= 1'b0;
            fe_half_old_q <= 1'b0;
        end else begin
            fp_old_q      <= fp_now_q;
            fp_now_q      <= fp_i;
            fe_now_q      <= fe_i;
            fe_half_old_q <= fe_half_new_q;
        end
    end

    // falling-edge sample gives the odd half-period positions
    always_ff @(negedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fe_half_new_q <= 1'b0;
        end else begin
            fe_half_new_q <= fe_i;
        end
    end

endmodule

// File: rtl/fskew_locator.sv
module fskew_locator (
    input  logic mode_i,
    input  logic fp_now,
    input  logic fp_old,
    input  logic fe_half_old,
    input  logic fe_now,
    input  logic fe_half_new,
    output logic fp_evt,
    output logic hit_even,
    output logic hit_odd
);

    logic n_fp_now, n_fp_old;
    logic n_fe_ho, n_fe_now, n_fe_hn;

    // normalise so that the active edge is always 0 -> 1
    always_comb begin
        n_fp_now = mode_i ? fp_now      : ~fp_now;
        n_fp_old = mode_i ? fp_old      : ~fp_old;
        n_fe_ho  = mode_i ? fe_half_old : ~fe_half_old;
        n_fe_now = mode_i ? fe_now      : ~fe_now;
        n_fe_hn  = mode_i ? fe_half_new : ~fe_half_new;

        fp_evt   = n_fp_now & ~n_fp_old;
        hit_even = n_fe_now & ~n_fe_ho;
        hit_odd  = n_fe_hn  & ~n_fe_now;
    end

endmodule

// File: rtl/frame_skew_meter.sv
module frame_skew_meter #(
    parameter int RES_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             mode_i,
    input  logic             start_i,
    input  logic             fp_i,
    input  logic             fe_i,
    output logic             done_o,
    output logic [RES_W-1:0] result_o
);

    import fskew_pkg::*;

    localparam int             QW       = $clog2(QUAL_EDGES + 1);
    localparam logic [QW-1:0]  QUAL_MAX = QW'(QUAL_EDGES);
    localparam logic [RES_W-1:0] NO_EDGE = '1;
    localparam logic [RES_W-1:0] CLAMP   = NO_EDGE - RES_W'(1);

    typedef struct packed {
        meas_state_e      st;
        logic             start_q;
        logic [QW-1:0]    qual;
        logic [RES_W-1:0] hc;
        logic [RES_W-1:0] cap;
        logic             found;
        logic             done;
        logic [RES_W-1:0] res;
    } regs_t;

    regs_t r_d, r_q;

    logic fp_now, fp_old, fe_half_old, fe_now, fe_half_new;
    logic fp_evt, hit_even, hit_odd;

    logic             rise;
    logic             hit;
    logic [RES_W-1:0] base;
    logic [RES_W-1:0] base_p1;
    logic [RES_W-1:0] base_p2;
    logic [RES_W-1:0] idx;

    fskew_sampler u_sampler (
        .clk           (clk),
        .rst_n         (rst_n),
        .fp_i          (fp_i),
        .fe_i          (fe_i),
        .fp_now_q      (fp_now),
        .fp_old_q      (fp_old),
        .fe_half_old_q (fe_half_old),
        .fe_now_q      (fe_now),
        .fe_half_new_q (fe_half_new)
    );

    fskew_locator u_locator (
        .mode_i      (mode_i),
        .fp_now      (fp_now),
        .fp_old      (fp_old),
        .fe_half_old (fe_half_old),
        .fe_now      (fe_now),
        .fe_half_new (fe_half_new),
        .fp_evt      (fp_evt),
        .hit_even    (hit_even),
        .hit_odd     (hit_odd)
    );

    always_comb begin
        r_d = r_q;
        r_d.start_q = start_i;

        rise = start_i & ~r_q.start_q;

        // half-period position of the even sample in this evaluation
        base    = fp_evt ? '0 : r_q.hc;
        base_p1 = (base >= CLAMP) ? CLAMP : base + RES_W'(1);
        base_p2 = (base >= CLAMP - RES_W'(1)) ? CLAMP : base + RES_W'(2);
        r_d.hc  = base_p2;

        hit = hit_even | hit_odd;
        idx = hit_even ? base : base_p1;

        // low-time qualification, counted in frame-pulse edges
        if (start_i) begin
            r_d.qual = '0;
        end else if (fp_evt && (r_q.qual != QUAL_MAX)) begin
            r_d.qual = r_q.qual + QW'(1);
        end

        unique case (r_q.st)
            MS_IDLE: begin
                if (rise && (r_q.qual == QUAL_MAX)) begin
                    r_d.st    = MS_ARMED;
                    r_d.cap   = NO_EDGE;
                    r_d.found = 1'b0;
                end
            end
            MS_ARMED: begin
                if (!start_i) begin
                    r_d.st = MS_IDLE;
                end else if (fp_evt) begin
                    r_d.st = MS_WINDOW;
                    if (hit) begin
                        r_d.found = 1'b1;
                        r_d.cap   = idx;
                    end
                end
            end
            MS_WINDOW: begin
                if (!start_i) begin
                    r_d.st = MS_IDLE;
                end else if (fp_evt) begin
                    r_d.st   = MS_DONE;
                    r_d.done = 1'b1;
                    r_d.res  = r_q.cap;
                end else if (hit && !r_q.found) begin
                    r_d.found = 1'b1;
                    r_d.cap   = idx;
                end
            end
            MS_DONE: begin
                if (!start_i) begin
                    r_d.st   = MS_IDLE;
                    r_d.done = 1'b0;
                end
            end
            default: r_d.st = MS_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.st      <= MS_IDLE;
            r_q.start_q <= 1'b0;
            r_q.qual    <= '0;
            r_q.hc      <= '0;
            r_q.cap     <= '0;
            r_q.found   <= 1'b0;
            r_q.done    <= 1'b0;
            r_q.res     <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign done_o   = r_q.done;
    assign result_o = r_q.res;

endmodule

// File: rtl/fskew_chk.sv
module fskew_chk #(
    parameter int RES_W = 12
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start_i,
    input logic             fp_evt,
    input logic             done_o,
    input logic [RES_W-1:0] result_o
);

    // R8
    done_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !start_i) |=> !done_o);

    // R3
    done_on_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done_o) |-> $past(fp_evt));

    // R2
    done_needs_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done_o) |-> $past(start_i));

    // R9
    result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$rose(done_o) |-> $stable(result_o));

endmodule

bind frame_skew_meter fskew_chk #(.RES_W(RES_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .start_i  (start_i),
    .fp_evt   (fp_evt),
    .done_o   (done_o),
    .result_o (result_o)
);

// File: tb/tb_frame_skew_meter.sv
module tb_frame_skew_meter;

    localparam int CLK_PERIOD = 20;
    localparam int HALF       = CLK_PERIOD / 2;
    localparam int FRAME      = 32;
    localparam int STEPS      = 2 * FRAME;
    localparam int RW         = 12;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic mode = 1'b0;
    logic start = 1'b0;
    logic fp = 1'b1;
    logic fe = 1'b1;
    logic done;
    logic [RW-1:0] res;

    int checks = 0;
    int fails = 0;
    int fp_edges = 0;
    int start_mark = 0;
    logic [RW-1:0] last_res = '0;

    logic [RW-1:0] expq[$];
    string         tagq[$];

    always #(HALF) clk = ~clk;

    frame_skew_meter #(.RES_W(RW)) dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .mode_i   (mode),
        .start_i  (start),
        .fp_i     (fp),
        .fe_i     (fe),
        .done_o   (done),
        .result_o (res)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic report();
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    endtask

    // one frame in half-period steps; h1/h2 < 0 mean no evaluation pulse
    task automatic run_frame(input int h1, input int h2, input int st_step, input bit st_val);
        for (int j = 0; j < STEPS; j++) begin
            logic act;
            act = mode;
            fp = (j < 4) ? act : ~act;
            fe = ((h1 >= 0 && j >= h1 && j < h1 + 4) ||
                  (h2 >= 0 && j >= h2 && j < h2 + 4)) ? act : ~act;
            if (j == 0) fp_edges++;
            if (j == st_step) start = st_val;
            #(HALF);
        end
    endtask

    task automatic measure(input bit m, input int h1, input int h2,
                           input logic [RW-1:0] exp, input string tag);
        mode  = m;
        start = 1'b0;
        run_frame(-1, -1, -1, 1'b0);
        run_frame(-1, -1, -1, 1'b0);
        run_frame(-1, -1, 20, 1'b1);
        expq.push_back(exp);
        tagq.push_back(tag);
        start_mark = fp_edges;
        run_frame(h1, h2, -1, 1'b0);
        run_frame(-1, -1, -1, 1'b0);
        chk(done === 1'b1, "R3 done held high", int'(done), 1);
        start = 1'b0;
        #(4 * HALF);
        chk(done === 1'b0, "R8 done clear", int'(done), 0);
        chk(res === exp, "R8 result hold", int'(res), int'(exp));
        last_res = exp;
    endtask

    // monitor: compare each completion with the scoreboard
    logic done_prev = 1'b0;
    logic [RW-1:0] mon_e;
    string mon_tag;
    always @(negedge clk) begin
        if (rst_n && done && !done_prev) begin
            if (expq.size() == 0) begin
                chk(1'b0, "R2/R9 unexpected done", 1, 0);
            end else begin
                mon_e   = expq.pop_front();
                mon_tag = tagq.pop_front();
                chk(res === mon_e, mon_tag, int'(res), int'(mon_e));
                chk((fp_edges - start_mark) == 2, "R3 completion frame",
                    fp_edges - start_mark, 2);
            end
        end
        done_prev = done;
    end

    initial begin
        #(CLK_PERIOD * 150000);
        chk(1'b0, "watchdog", 0, 1);
        report();
    end

    initial begin
        // align to a quarter period before a rising edge
        @(negedge clk);
        #(HALF / 2);
        #(4 * HALF);
        chk(done === 1'b0, "R1 reset done", int'(done), 0);
        chk(res === '0, "R1 reset result", int'(res), 0);
        rst_n = 1'b1;
        #(4 * HALF);
        chk(done === 1'b0, "R1 after release done", int'(done), 0);
        chk(res === '0, "R1 after release result", int'(res), 0);

        measure(1'b0, 5, -1, 12'd5, "R4 R5 falling h5");
        measure(1'b0, 0, -1, 12'd0, "R4 R5 falling h0");
        measure(1'b1, 7, -1, 12'd7, "R4 R6 rising h7");
        measure(1'b1, 40, -1, 12'd40, "R4 R6 rising h40");
        measure(1'b0, -1, -1, 12'hFFF, "R7 no edge");
        measure(1'b1, 9, 30, 12'd9, "R10 first edge wins");

        // R2: start low for less than one frame, rise ignored
        start = 1'b0;
        run_frame(-1, -1, 20, 1'b1);
        run_frame(6, -1, -1, 1'b0);
        run_frame(-1, -1, -1, 1'b0);
        run_frame(-1, -1, -1, 1'b0);
        chk(done === 1'b0, "R2 unqualified start", int'(done), 0);
        chk(res === last_res, "R2 result unchanged", int'(res), int'(last_res));
        start = 1'b0;

        // R9: abandon mid measurement
        run_frame(-1, -1, -1, 1'b0);
        run_frame(-1, -1, -1, 1'b0);
        run_frame(-1, -1, 20, 1'b1);
        run_frame(10, -1, 40, 1'b0);
        run_frame(-1, -1, -1, 1'b0);
        run_frame(-1, -1, -1, 1'b0);
        chk(done === 1'b0, "R9 abort no done", int'(done), 0);
        chk(res === last_res, "R9 result unchanged", int'(res), int'(last_res));

        measure(1'b0, 13, -1, 12'd13, "R4 R5 recovery h13");

        #(4 * HALF);
        report();
    end

endmodule